// File: doc/BRIEF.md
# Supply Monitor Reset Sequencer

This block sits between three supply comparators and a controller core. The comparators have already been synchronized to the core clock. Each one reports whether the supply is under one of three ordered levels: a warning level, a minimum operating level and the backup-cell level. The block turns those flags into the core's response to a failing or recovering supply.

Entering the warning region raises a one-shot interrupt request, but only when software has enabled it. The request carries a fixed vector. Falling under the minimum level holds the core in reset. During that reset the block pulls an open-drain reset line low and forces every decoded chip enable and the write strobe to their inactive high level. The same reset line is also sensed, so a neighbour that pulls it low resets this device as well. When the supply is under the backup-cell level, an active-low backup flag goes low.

Reset is released only once a power-on delay, counted in clock cycles, has run out with no fault at all. Any new fault starts the delay again from zero.

Top module: `supply_reset_seq`

## Requirements
- R1: On the first cycle that `below_warn` is sampled high after being low, and `warn_irq_en` is high in that cycle, `irq_req` is high for exactly one cycle, starting the cycle after. `irq_vec` always reads 8'h2B.
- R2: No request is made for an entry while `warn_irq_en` is low. Staying in the warning region makes no further request. Leaving the region and entering it again makes a new request.
- R3: When `below_min` is sampled high, `core_reset` is high from the next cycle on and stays high while `below_min` stays high.
- R4: `rst_pin_drive_low` is high in the cycle after each cycle in which `below_min` is sampled high, and low otherwise. A low caused only from outside does not make the block drive the line.
- R5: A low level on `rst_pin_in` is a fault like `below_min`, and puts `core_reset` high from the next cycle on.
- R6: `core_reset` falls only after POR_CYCLES consecutive clock edges with no fault (no `below_min`, and `rst_pin_in` high). Any fault restarts the delay from zero. After `rst_n` is released the same delay applies.
- R7: While `core_reset` is high, `ce_n_out` is all ones and `rw_n_out` is 1. Otherwise both equal `ce_n_in` and `rw_n_in`.
- R8: `backup_n` is low in the cycle after `below_backup` is sampled high, and high in the cycle after it is sampled low.
- R9: While `rst_n` is low at a clock edge, the outputs take these values: `core_reset`=1, `irq_req`=0, `rst_pin_drive_low`=0, `backup_n`=1, `por_count`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| below_warn | input | 1 | Supply is under the warning level |
| below_min | input | 1 | Supply is under the minimum operating level |
| below_backup | input | 1 | Supply is under the backup-cell level |
| warn_irq_en | input | 1 | Enables the warning interrupt |
| rst_pin_in | input | 1 | Sensed level of the shared open-drain reset line |
| ce_n_in | input | NUM_CE | Decoded chip enables from the bus unit, active low |
| rw_n_in | input | 1 | Write strobe from the bus unit, active low |
| ce_n_out | output | NUM_CE | Chip enables after reset gating |
| rw_n_out | output | 1 | Write strobe after reset gating |
| irq_req | output | 1 | One-cycle warning interrupt request |
| irq_vec | output | VEC_W | Interrupt vector address |
| core_reset | output | 1 | Internal reset to the core, active high |
| rst_pin_drive_low | output | 1 | Open-drain pull-down enable for the reset line |
| backup_n | output | 1 | Low while the supply is under the backup-cell level |
| por_count | output | CNT_W | Power-on delay count in progress |

## Verification
The bench builds the block with POR_CYCLES set to 16. This shortens the delay so the exact release edge can be checked after reset, after a supply dip, and after an external pull-down that interrupts a running delay. NUM_CE is kept at 4, so every chip-enable bit is seen both forced high and passed through. The bench models the wired-AND reset line itself. This exposes the extra cycle in which the block's own pull-down is still visible on the line, which delays release after a supply dip by one edge.

// File: rtl/sm_pkg.sv
// Package: shared defaults for the supply monitor reset sequencer.
// Assumes: nothing; holds constants only.
package sm_pkg;
    localparam int unsigned SM_POR_DEFAULT = 21504;  // power-on delay in clocks
    localparam int unsigned SM_VEC_W       = 8;
    localparam logic [SM_VEC_W-1:0] SM_WARN_VECTOR = 8'h2B;
endpackage

// File: rtl/sm_por_timer.sv
// Module: sm_por_timer
// Holds reset while a fault is present, then counts POR_CYCLES clean edges
// before releasing. Assumes fault is synchronous to clk.
module sm_por_timer #(
    parameter int unsigned POR_CYCLES = 21504,
    localparam int unsigned CNT_W = (POR_CYCLES > 1) ? $clog2(POR_CYCLES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault,
    output logic             in_reset,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(POR_CYCLES - 1);

    // Purpose: restart on any fault, otherwise advance until the delay ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_reset <= 1'b1;
            count    <= '0;
        end else if (fault) begin
            in_reset <= 1'b1;
            count    <= '0;
        end else if (in_reset) begin
            if (count == LAST) begin
                in_reset <= 1'b0;
                count    <= '0;
            end else begin
                count <= count + 1'b1;
            end
        end
    end

    AST_FAULT_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (in_reset && count == '0)); // R6
    AST_RELEASE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_reset) |-> ($past(count) == LAST && !$past(fault))); // R6
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST); // R6
endmodule

// File: rtl/sm_warn_irq.sv
// Module: sm_warn_irq
// Issues one request per entry into the warning region when enabled.
// Assumes below_warn is synchronous to clk.
module sm_warn_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic below_warn,
    input  logic irq_en,
    output logic irq_req
);
    logic warn_q;

    // Purpose: remember the previous warning level and flag a rising entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warn_q  <= 1'b0;
            irq_req <= 1'b0;
        end else begin
            warn_q  <= below_warn;
            irq_req <= below_warn && !warn_q && irq_en;
        end
    end

    AST_IRQ_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> !irq_req); // R2
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ($past(irq_en) && $past(below_warn))); // R1
endmodule

// File: rtl/sm_bus_gate.sv
// Module: sm_bus_gate
// Forces active-low bus strobes inactive while the core is held in reset.
// Assumes strobes are active low.
module sm_bus_gate #(
    parameter int unsigned NUM_CE = 4
) (
    input  logic              hold,
    input  logic [NUM_CE-1:0] ce_n_in,
    input  logic              rw_n_in,
    output logic [NUM_CE-1:0] ce_n_out,
    output logic              rw_n_out
);
    // Purpose: gate each chip enable individually.
    for (genvar g = 0; g < NUM_CE; g++) begin : g_ce
        assign ce_n_out[g] = ce_n_in[g] | hold;
    end
    assign rw_n_out = rw_n_in | hold;
endmodule

// File: rtl/supply_reset_seq.sv
// Module: supply_reset_seq
// Maps three ordered supply comparator flags to a warning interrupt, a core
// reset with power-on delay, a shared open-drain reset line and a backup flag.
// Assumes all comparator inputs and rst_pin_in are already synchronized.
module supply_reset_seq #(
    parameter int unsigned POR_CYCLES = sm_pkg::SM_POR_DEFAULT,
    parameter int unsigned NUM_CE     = 4,
    parameter int unsigned VEC_W      = sm_pkg::SM_VEC_W,
    parameter logic [VEC_W-1:0] WARN_VEC = VEC_W'(sm_pkg::SM_WARN_VECTOR),
    localparam int unsigned CNT_W = (POR_CYCLES > 1) ? $clog2(POR_CYCLES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              below_warn,
    input  logic              below_min,
    input  logic              below_backup,
    input  logic              warn_irq_en,
    input  logic              rst_pin_in,
    input  logic [NUM_CE-1:0] ce_n_in,
    input  logic              rw_n_in,
    output logic [NUM_CE-1:0] ce_n_out,
    output logic              rw_n_out,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec,
    output logic              core_reset,
    output logic              rst_pin_drive_low,
    output logic              backup_n,
    output logic [CNT_W-1:0]  por_count
);
    logic fault;

    // Purpose: a low supply or a low shared reset line is a fault.
    assign fault   = below_min | ~rst_pin_in;
    assign irq_vec = WARN_VEC;

    sm_por_timer #(.POR_CYCLES(POR_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault    (fault),
        .in_reset (core_reset),
        .count    (por_count)
    );

    sm_warn_irq u_warn (
        .clk        (clk),
        .rst_n      (rst_n),
        .below_warn (below_warn),
        .irq_en     (warn_irq_en),
        .irq_req    (irq_req)
    );

    sm_bus_gate #(.NUM_CE(NUM_CE)) u_gate (
        .hold     (core_reset),
        .ce_n_in  (ce_n_in),
        .rw_n_in  (rw_n_in),
        .ce_n_out (ce_n_out),
        .rw_n_out (rw_n_out)
    );

    // Purpose: register the line pull-down and the backup flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_pin_drive_low <= 1'b0;
            backup_n          <= 1'b1;
        end else begin
            rst_pin_drive_low <= below_min;
            backup_n          <= ~below_backup;
        end
    end

    AST_LOW_SUPPLY_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        below_min |=> core_reset); // R3
    AST_EXT_LOW_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_pin_in |=> core_reset); // R5
    AST_PIN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        below_min |=> rst_pin_drive_low); // R4
    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        below_min |=> (&ce_n_out && rw_n_out)); // R7
    AST_BACKUP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        below_backup |=> !backup_n); // R8
endmodule

// File: tb/sim_supply_reset_seq.sv
module sim_supply_reset_seq;
    localparam int POR = 16;
    localparam int NCE = 4;
    localparam int NV  = 10;
    // {warn, en, bkup, ce[3:0], rw, exp_irq, exp_bkn, exp_ce[3:0], exp_rw}
    localparam logic [14:0] TBL [NV] = '{
        {3'b010, 4'b1110, 1'b1, 1'b0, 1'b1, 4'b1110, 1'b1},
        {3'b110, 4'b1101, 1'b0, 1'b1, 1'b1, 4'b1101, 1'b0},
        {3'b110, 4'b1011, 1'b1, 1'b0, 1'b1, 4'b1011, 1'b1},
        {3'b011, 4'b0111, 1'b0, 1'b0, 1'b0, 4'b0111, 1'b0},
        {3'b101, 4'b1111, 1'b1, 1'b0, 1'b0, 4'b1111, 1'b1},
        {3'b000, 4'b0000, 1'b1, 1'b0, 1'b1, 4'b0000, 1'b1},
        {3'b110, 4'b1010, 1'b0, 1'b1, 1'b1, 4'b1010, 1'b0},
        {3'b010, 4'b0101, 1'b1, 1'b0, 1'b1, 4'b0101, 1'b1},
        {3'b110, 4'b0011, 1'b1, 1'b1, 1'b1, 4'b0011, 1'b1},
        {3'b110, 4'b1100, 1'b0, 1'b0, 1'b1, 4'b1100, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n, below_warn, below_min, below_backup, warn_irq_en, ext_low;
    logic rst_pin_in, rw_n_in, rw_n_out, irq_req, core_reset, drv, backup_n;
    logic [NCE-1:0] ce_n_in, ce_n_out;
    logic [7:0] irq_vec;
    logic [3:0] por_count;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;
    assign rst_pin_in = ~(drv | ext_low);  // wired-AND line with pull-up

    supply_reset_seq #(.POR_CYCLES(POR), .NUM_CE(NCE)) u0 (
        .clk(clk), .rst_n(rst_n), .below_warn(below_warn), .below_min(below_min),
        .below_backup(below_backup), .warn_irq_en(warn_irq_en),
        .rst_pin_in(rst_pin_in), .ce_n_in(ce_n_in), .rw_n_in(rw_n_in),
        .ce_n_out(ce_n_out), .rw_n_out(rw_n_out), .irq_req(irq_req),
        .irq_vec(irq_vec), .core_reset(core_reset), .rst_pin_drive_low(drv),
        .backup_n(backup_n), .por_count(por_count));

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #(4 * 5000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; below_warn = 0; below_min = 0; below_backup = 0;
        warn_irq_en = 0; ext_low = 0; ce_n_in = '1; rw_n_in = 1'b1;
        step(3);
        // R9 reset state
        chk("R9 core_reset", core_reset, 1);
        chk("R9 irq_req", irq_req, 0);
        chk("R9 drive", drv, 0);
        chk("R9 backup_n", backup_n, 1);
        chk("R9 por_count", por_count, 0);
        chk("R7 ce forced in reset", ce_n_out, 4'hF);
        // R6 delay after rst_n release
        rst_n = 1'b1;
        step(POR - 1);
        chk("R6 still held before full delay", core_reset, 1);
        step(1);
        chk("R6 released after full delay", core_reset, 0);

        // Table: R1 R2 R7 R8
        for (int i = 0; i < NV; i++) begin
            {below_warn, warn_irq_en, below_backup, ce_n_in, rw_n_in} = TBL[i][14:7];
            step(1);
            chk($sformatf("R1/R2 irq_req row %0d", i), irq_req, TBL[i][6]);
            chk($sformatf("R8 backup_n row %0d", i), backup_n, TBL[i][5]);
            chk($sformatf("R7 ce pass row %0d", i), ce_n_out, TBL[i][4:1]);
            chk($sformatf("R7 rw pass row %0d", i), rw_n_out, TBL[i][0]);
        end
        chk("R1 vector", irq_vec, 8'h2B);
        below_warn = 0; below_backup = 0; warn_irq_en = 0;

        // R3 R4 R7: supply dip
        ce_n_in = 4'h0; rw_n_in = 1'b0; below_min = 1'b1;
        step(1);
        chk("R3 reset on low supply", core_reset, 1);
        chk("R4 line driven", drv, 1);
        chk("R7 ce forced", ce_n_out, 4'hF);
        chk("R7 rw forced", rw_n_out, 1);
        step(3);
        chk("R3 held while low", core_reset, 1);
        below_min = 1'b0;
        step(1);
        chk("R4 drive released", drv, 0);
        step(POR - 1);
        chk("R6 held one edge for own pull-down", core_reset, 1);
        step(1);
        chk("R6 released after dip", core_reset, 0);
        chk("R7 ce pass after release", ce_n_out, 4'h0);

        // R5: external pull-down, and R6 restart
        ext_low = 1'b1;
        step(1);
        chk("R5 reset on external low", core_reset, 1);
        chk("R4 no drive for external low", drv, 0);
        ext_low = 1'b0;
        step(8);
        ext_low = 1'b1;
        step(1);
        ext_low = 1'b0;
        step(POR - 1);
        chk("R6 restart holds reset", core_reset, 1);
        step(1);
        chk("R6 release after restart", core_reset, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule